// File: doc/BRIEF.md
# Split-Array Level-1 Translation Buffer

This block translates virtual page numbers into physical page numbers for one access port of a core. It keeps two arrays and searches both in the same cycle. The first is a four-slot fully associative array whose slots may each describe a page of any of nine sizes. The second is a 64-slot array of 16 sets by 4 ways that only describes 4 KB pages. A lookup takes a 20-bit virtual page number (virtual address bits 31:12) and an 8-bit process tag. A hit returns the physical page number, a 3-bit permission field, which array answered and a multi-hit flag.

When both arrays miss, the block raises a refill request to a level-2 translation unit and reports busy. It ignores new lookups until the level-2 answer arrives. The answer says which array to fill. The block installs it over the round-robin victim and then replays the stored lookup. Invalidate requests, whether from the local core or snooped from another agent, clear every slot in either array that maps the given page for the given process tag. An invalidate that names the pending page while a refill is outstanding causes the later answer to be dropped.

Top module: `l1_split_tlb`

## Requirements
- R1: After reset `lk_busy`, `rsp_valid` and `rf_req_valid` are 0, and every slot is empty, so the first lookup misses.
- R2: A lookup accepted while not busy that hits raises `rsp_valid` for exactly one cycle, one clock edge later, with the slot's `rsp_ppn` and `rsp_perm`.
- R3: Size code k (0 to 8) on a variable-array slot means a page of 4 KB times 4^k, and codes above 8 act as 8. A slot matches when page-number bits 19 down to 2k agree. The returned page number takes bits below 2k from the lookup.
- R4: The 4 KB array uses page-number bits 3:0 (address bits 15:12) as set index. It hits only when bits 19:4 and the process tag both match, so a different process tag misses.
- R5: On a miss, `lk_busy` and `rf_req_valid` rise one edge after the lookup, with `rf_req_vpn`/`rf_req_pid` equal to the missed lookup. They are held until `rf_rsp_valid`. Lookups presented while busy are ignored.
- R6: `rf_rsp_valid` installs the entry into the variable array when `rf_rsp_to_vsp` is 1 (using `rf_rsp_psz`), else into the 4 KB array. Two edges later `rsp_valid` rises for the replayed lookup and `lk_busy` falls.
- R7: When both arrays hit, the variable array's result is returned and `rsp_from_vsp` is 1. A hit from the 4 KB array alone gives `rsp_from_vsp` 0.
- R8: When more than one slot of one array hits, `rsp_multihit` is 1 and the lowest-numbered matching slot supplies the result.
- R9: `inv_valid` clears, in both arrays, every slot whose page covers `inv_vpn` and whose tag equals `inv_pid`. Slots with another process tag are kept.
- R10: An invalidate whose page number and tag equal the pending request, arriving while the refill is outstanding, discards the answer. The replay then misses and a new refill request for the same page is raised.
- R11: Each set of the 4 KB array fills its ways in the order 0, 1, 2, 3 and then wraps to 0, so the fifth install into a set evicts the first.
- R12: The variable array has one replacement pointer that steps 0, 1, 2, 3 and then 0 on each install into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_pid | input | 8 | Lookup process tag |
| lk_busy | output | 1 | Refill outstanding or replay in progress; lookups ignored |
| rsp_valid | output | 1 | Translation result valid (always a hit) |
| rsp_ppn | output | 20 | Physical page number |
| rsp_perm | output | 3 | Permission bits |
| rsp_from_vsp | output | 1 | 1 when the variable-size array answered |
| rsp_multihit | output | 1 | More than one slot of one array matched |
| rf_req_valid | output | 1 | Refill request to the level-2 unit |
| rf_req_vpn | output | 20 | Page number to refill |
| rf_req_pid | output | 8 | Process tag to refill |
| rf_rsp_valid | input | 1 | Refill answer present |
| rf_rsp_to_vsp | input | 1 | 1: fill variable array, 0: fill 4 KB array |
| rf_rsp_psz | input | 4 | Page size code for the variable array |
| rf_rsp_ppn | input | 20 | Physical page number of the answer |
| rf_rsp_perm | input | 3 | Permission bits of the answer |
| inv_valid | input | 1 | Invalidate request (local or snooped) |
| inv_vpn | input | 20 | Page number to invalidate |
| inv_pid | input | 8 | Process tag to invalidate |

## Verification
The bench puts a 4 KB slot and a 64 KB slot over the same page. A design that got priority wrong would return the 4 KB physical page and clear `rsp_from_vsp`. It overlaps two variable-size slots to trigger the multi-hit case, where a wrong priority encoder would return the higher slot's page. Five installs into one 4 KB set and five into the variable array check the eviction order: a wrong pointer would evict a still-needed page, and the bench sees that as an unexpected miss. It also checks the in-page bits merged from 1 MB and 256 MB pages, an invalidate that names a foreign process tag, and an invalidate that lands during an outstanding refill. A design that installed the stale answer would hit on replay instead of asking again.

// File: rtl/l1tlb_pkg.sv
// Package: shared widths and controller state encoding for the split
// level-1 translation buffer. Assumes 4 KB base pages and 32-bit addresses.
package l1tlb_pkg;
    localparam int VPN_W   = 20;  // virtual/physical page number width
    localparam int PID_W   = 8;   // process tag width
    localparam int PERM_W  = 3;   // permission field width
    localparam int PSZ_W   = 4;   // page size code width
    localparam int NUM_PSZ = 9;   // number of legal page size codes

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_REPLAY = 2'd2
    } tlb_state_e;
endpackage

// File: rtl/l1tlb_vsp_array.sv
// Module: fully associative array of variable page size slots.
// Compares only page-number bits above each slot's size; returns the lowest
// matching slot. Installs use a single round-robin pointer. Invalidates are
// applied before a same-cycle install. Assumes ENTRIES >= 2.
module l1tlb_vsp_array #(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = l1tlb_pkg::VPN_W,
    parameter int PID_W   = l1tlb_pkg::PID_W,
    parameter int PERM_W  = l1tlb_pkg::PERM_W,
    parameter int PSZ_W   = l1tlb_pkg::PSZ_W,
    parameter int NUM_PSZ = l1tlb_pkg::NUM_PSZ
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lu_vpn,
    input  logic [PID_W-1:0]  lu_pid,
    output logic              hit,
    output logic              multi,
    output logic [VPN_W-1:0]  out_ppn,
    output logic [PERM_W-1:0] out_perm,
    input  logic              wr_en,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PID_W-1:0]  wr_pid,
    input  logic [PSZ_W-1:0]  wr_psz,
    input  logic [VPN_W-1:0]  wr_ppn,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic              inv_en,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic [PID_W-1:0]  inv_pid
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);
    localparam logic [PSZ_W-1:0] MAX_PSZ  = PSZ_W'(NUM_PSZ - 1);

    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   vpn_q  [ENTRIES];
    logic [PID_W-1:0]   pid_q  [ENTRIES];
    logic [PSZ_W-1:0]   psz_q  [ENTRIES];
    logic [VPN_W-1:0]   ppn_q  [ENTRIES];
    logic [PERM_W-1:0]  perm_q [ENTRIES];
    logic [IDX_W-1:0]   ptr_q;

    logic [VPN_W-1:0]   mask   [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] inv_vec;
    logic [IDX_W-1:0]   sel;
    logic [PSZ_W-1:0]   psz_clamped;

    // Per-slot size mask and match against the lookup and the invalidate.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        assign mask[i]    = {VPN_W{1'b1}} << {psz_q[i], 1'b0};
        assign hit_vec[i] = valid_q[i] && (pid_q[i] == lu_pid) &&
                            (((vpn_q[i] ^ lu_vpn) & mask[i]) == '0);
        assign inv_vec[i] = valid_q[i] && (pid_q[i] == inv_pid) &&
                            (((vpn_q[i] ^ inv_vpn) & mask[i]) == '0);
    end

    // Lowest-index priority select among matching slots.
    always_comb begin
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) sel = IDX_W'(i);
        end
    end

    assign hit      = |hit_vec;
    assign multi    = $countones(hit_vec) > 1;
    assign out_ppn  = (ppn_q[sel] & mask[sel]) | (lu_vpn & ~mask[sel]);
    assign out_perm = perm_q[sel];
    assign psz_clamped = (wr_psz > MAX_PSZ) ? MAX_PSZ : wr_psz;

    // Slot state: invalidate first, then install at the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (inv_en && inv_vec[i]) valid_q[i] <= 1'b0;
            end
            if (wr_en) begin
                valid_q[ptr_q] <= 1'b1;
                ptr_q          <= (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
            end
        end
    end

    // Slot payload: written on install only.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            vpn_q[ptr_q]  <= wr_vpn;
            pid_q[ptr_q]  <= wr_pid;
            psz_q[ptr_q]  <= psz_clamped;
            ppn_q[ptr_q]  <= wr_ppn;
            perm_q[ptr_q] <= wr_perm;
        end
    end

    assert_vsp_rr_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ptr_q == (($past(ptr_q) == LAST_IDX) ? '0 : $past(ptr_q) + 1'b1));

    assert_vsp_install_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(ptr_q)]);
endmodule

// File: rtl/l1tlb_4k_array.sv
// Module: set-associative array of 4 KB page slots.
// Set index is the low page-number bits; the tag is the rest plus the
// process tag. Each set keeps its own round-robin victim pointer.
// Assumes SETS and WAYS are powers of two, WAYS >= 2.
module l1tlb_4k_array #(
    parameter int SETS   = 16,
    parameter int WAYS   = 4,
    parameter int VPN_W  = l1tlb_pkg::VPN_W,
    parameter int PID_W  = l1tlb_pkg::PID_W,
    parameter int PERM_W = l1tlb_pkg::PERM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lu_vpn,
    input  logic [PID_W-1:0]  lu_pid,
    output logic              hit,
    output logic              multi,
    output logic [VPN_W-1:0]  out_ppn,
    output logic [PERM_W-1:0] out_perm,
    input  logic              wr_en,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PID_W-1:0]  wr_pid,
    input  logic [VPN_W-1:0]  wr_ppn,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic              inv_en,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic [PID_W-1:0]  inv_pid
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = VPN_W - SET_W;
    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

    logic [WAYS-1:0]   valid_q [SETS];
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [PID_W-1:0]  pid_q   [SETS][WAYS];
    logic [VPN_W-1:0]  ppn_q   [SETS][WAYS];
    logic [PERM_W-1:0] perm_q  [SETS][WAYS];
    logic [WAY_W-1:0]  rr_q    [SETS];

    logic [SET_W-1:0]  lu_set, wr_set, inv_set;
    logic [WAYS-1:0]   hit_vec, inv_vec;
    logic [WAY_W-1:0]  sel;

    assign lu_set  = lu_vpn[SET_W-1:0];
    assign wr_set  = wr_vpn[SET_W-1:0];
    assign inv_set = inv_vpn[SET_W-1:0];

    // Per-way tag compare in the lookup set and in the invalidate set.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_vec[w] = valid_q[lu_set][w] && (pid_q[lu_set][w] == lu_pid) &&
                            (tag_q[lu_set][w] == lu_vpn[VPN_W-1:SET_W]);
        assign inv_vec[w] = valid_q[inv_set][w] && (pid_q[inv_set][w] == inv_pid) &&
                            (tag_q[inv_set][w] == inv_vpn[VPN_W-1:SET_W]);
    end

    // Lowest-way priority select among matching ways.
    always_comb begin
        sel = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) sel = WAY_W'(w);
        end
    end

    assign hit      = |hit_vec;
    assign multi    = $countones(hit_vec) > 1;
    assign out_ppn  = ppn_q[lu_set][sel];
    assign out_perm = perm_q[lu_set][sel];

    // Valid bits and victim pointers: invalidate first, then install.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                rr_q[s]    <= '0;
            end
        end else begin
            for (int w = 0; w < WAYS; w++) begin
                if (inv_en && inv_vec[w]) valid_q[inv_set][w] <= 1'b0;
            end
            if (wr_en) begin
                valid_q[wr_set][rr_q[wr_set]] <= 1'b1;
                rr_q[wr_set] <= (rr_q[wr_set] == LAST_WAY) ? '0 : rr_q[wr_set] + 1'b1;
            end
        end
    end

    // Way payload: written on install only.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][rr_q[wr_set]]  <= wr_vpn[VPN_W-1:SET_W];
            pid_q[wr_set][rr_q[wr_set]]  <= wr_pid;
            ppn_q[wr_set][rr_q[wr_set]]  <= wr_ppn;
            perm_q[wr_set][rr_q[wr_set]] <= wr_perm;
        end
    end

    assert_set_rr_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rr_q[$past(wr_set)] ==
                  (($past(rr_q[wr_set]) == LAST_WAY) ? '0 : $past(rr_q[wr_set]) + 1'b1));

    assert_set_install_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_set)][$past(rr_q[wr_set])]);
endmodule

// File: rtl/l1tlb_ctrl.sv
// Module: lookup sequencing, refill handshake and result register.
// Holds the missed request, raises the refill request until the answer,
// drops an answer made stale by a matching invalidate, replays the lookup
// and registers the combined result with the variable array given priority.
module l1tlb_ctrl #(
    parameter int VPN_W  = l1tlb_pkg::VPN_W,
    parameter int PID_W  = l1tlb_pkg::PID_W,
    parameter int PERM_W = l1tlb_pkg::PERM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [PID_W-1:0]  lk_pid,
    output logic              lk_busy,
    output logic [VPN_W-1:0]  lu_vpn,
    output logic [PID_W-1:0]  lu_pid,
    input  logic              vsp_hit,
    input  logic              vsp_multi,
    input  logic [VPN_W-1:0]  vsp_ppn,
    input  logic [PERM_W-1:0] vsp_perm,
    input  logic              k4_hit,
    input  logic              k4_multi,
    input  logic [VPN_W-1:0]  k4_ppn,
    input  logic [PERM_W-1:0] k4_perm,
    input  logic              rf_rsp_valid,
    input  logic              rf_rsp_to_vsp,
    input  logic              inv_valid,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic [PID_W-1:0]  inv_pid,
    output logic              vsp_wr,
    output logic              k4_wr,
    output logic              rf_req_valid,
    output logic [VPN_W-1:0]  rf_req_vpn,
    output logic [PID_W-1:0]  rf_req_pid,
    output logic              rsp_valid,
    output logic [VPN_W-1:0]  rsp_ppn,
    output logic [PERM_W-1:0] rsp_perm,
    output logic              rsp_from_vsp,
    output logic              rsp_multihit
);
    import l1tlb_pkg::*;

    tlb_state_e       state_q;
    logic [VPN_W-1:0] pend_vpn_q;
    logic [PID_W-1:0] pend_pid_q;
    logic             stale_q;

    logic lookup_act, any_hit, inv_on_pend, accept_rf, drop_rf;

    assign lookup_act  = ((state_q == ST_IDLE) && lk_valid) || (state_q == ST_REPLAY);
    assign any_hit     = vsp_hit || k4_hit;
    assign lu_vpn      = (state_q == ST_IDLE) ? lk_vpn : pend_vpn_q;
    assign lu_pid      = (state_q == ST_IDLE) ? lk_pid : pend_pid_q;
    assign inv_on_pend = inv_valid && (inv_vpn == pend_vpn_q) && (inv_pid == pend_pid_q);
    assign accept_rf   = (state_q == ST_WAIT) && rf_rsp_valid;
    assign drop_rf     = stale_q || inv_on_pend;
    assign vsp_wr      = accept_rf && !drop_rf && rf_rsp_to_vsp;
    assign k4_wr       = accept_rf && !drop_rf && !rf_rsp_to_vsp;
    assign lk_busy     = (state_q != ST_IDLE);
    assign rf_req_valid = (state_q == ST_WAIT);
    assign rf_req_vpn  = pend_vpn_q;
    assign rf_req_pid  = pend_pid_q;

    // Sequencer: idle -> wait on miss -> replay after answer -> idle on hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            pend_vpn_q <= '0;
            pend_pid_q <= '0;
            stale_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (lk_valid && !any_hit) begin
                        state_q    <= ST_WAIT;
                        pend_vpn_q <= lk_vpn;
                        pend_pid_q <= lk_pid;
                        stale_q    <= 1'b0;
                    end
                end
                ST_WAIT: begin
                    if (rf_rsp_valid) begin
                        state_q <= ST_REPLAY;
                        stale_q <= 1'b0;
                    end else if (inv_on_pend) begin
                        stale_q <= 1'b1;
                    end
                end
                ST_REPLAY: begin
                    state_q <= any_hit ? ST_IDLE : ST_WAIT;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Result register: variable array wins when both arrays hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_ppn      <= '0;
            rsp_perm     <= '0;
            rsp_from_vsp <= 1'b0;
            rsp_multihit <= 1'b0;
        end else begin
            rsp_valid <= lookup_act && any_hit;
            if (lookup_act && any_hit) begin
                rsp_ppn      <= vsp_hit ? vsp_ppn  : k4_ppn;
                rsp_perm     <= vsp_hit ? vsp_perm : k4_perm;
                rsp_from_vsp <= vsp_hit;
                rsp_multihit <= vsp_multi || k4_multi;
            end
        end
    end

    assert_rsp_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(state_q == ST_IDLE && lk_valid) || $past(state_q == ST_REPLAY)));

    assert_hold_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !rf_rsp_valid) |=> (state_q == ST_WAIT && $stable(pend_vpn_q)));

    assert_answer_replays_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept_rf |=> state_q == ST_REPLAY);

    assert_vsp_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lookup_act && vsp_hit && k4_hit) |-> (rsp_valid && rsp_from_vsp));

    assert_stale_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && stale_q && rf_rsp_valid) |-> !(vsp_wr || k4_wr));

    assert_one_writer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vsp_wr, k4_wr}));
endmodule

// File: rtl/l1_split_tlb.sv
// Module: top of the split-array level-1 translation buffer.
// Wires the variable-size array, the 4 KB array and the controller. Refill
// installs use the pending request's page number and tag with the level-2
// answer's payload; invalidates reach both arrays unconditionally.
module l1_split_tlb #(
    parameter int VSP_ENTRIES = 4,
    parameter int K4_SETS     = 16,
    parameter int K4_WAYS     = 4,
    parameter int VPN_W       = l1tlb_pkg::VPN_W,
    parameter int PID_W       = l1tlb_pkg::PID_W,
    parameter int PERM_W      = l1tlb_pkg::PERM_W,
    parameter int PSZ_W       = l1tlb_pkg::PSZ_W,
    parameter int NUM_PSZ     = l1tlb_pkg::NUM_PSZ
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [PID_W-1:0]  lk_pid,
    output logic              lk_busy,
    output logic              rsp_valid,
    output logic [VPN_W-1:0]  rsp_ppn,
    output logic [PERM_W-1:0] rsp_perm,
    output logic              rsp_from_vsp,
    output logic              rsp_multihit,
    output logic              rf_req_valid,
    output logic [VPN_W-1:0]  rf_req_vpn,
    output logic [PID_W-1:0]  rf_req_pid,
    input  logic              rf_rsp_valid,
    input  logic              rf_rsp_to_vsp,
    input  logic [PSZ_W-1:0]  rf_rsp_psz,
    input  logic [VPN_W-1:0]  rf_rsp_ppn,
    input  logic [PERM_W-1:0] rf_rsp_perm,
    input  logic              inv_valid,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic [PID_W-1:0]  inv_pid
);
    logic [VPN_W-1:0]  lu_vpn;
    logic [PID_W-1:0]  lu_pid;
    logic              vsp_hit, vsp_multi, k4_hit, k4_multi;
    logic [VPN_W-1:0]  vsp_ppn, k4_ppn;
    logic [PERM_W-1:0] vsp_perm, k4_perm;
    logic              vsp_wr, k4_wr;

    l1tlb_vsp_array #(
        .ENTRIES(VSP_ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W),
        .PERM_W(PERM_W), .PSZ_W(PSZ_W), .NUM_PSZ(NUM_PSZ)
    ) u_vsp (
        .clk(clk), .rst_n(rst_n),
        .lu_vpn(lu_vpn), .lu_pid(lu_pid),
        .hit(vsp_hit), .multi(vsp_multi), .out_ppn(vsp_ppn), .out_perm(vsp_perm),
        .wr_en(vsp_wr), .wr_vpn(rf_req_vpn), .wr_pid(rf_req_pid),
        .wr_psz(rf_rsp_psz), .wr_ppn(rf_rsp_ppn), .wr_perm(rf_rsp_perm),
        .inv_en(inv_valid), .inv_vpn(inv_vpn), .inv_pid(inv_pid)
    );

    l1tlb_4k_array #(
        .SETS(K4_SETS), .WAYS(K4_WAYS), .VPN_W(VPN_W),
        .PID_W(PID_W), .PERM_W(PERM_W)
    ) u_k4 (
        .clk(clk), .rst_n(rst_n),
        .lu_vpn(lu_vpn), .lu_pid(lu_pid),
        .hit(k4_hit), .multi(k4_multi), .out_ppn(k4_ppn), .out_perm(k4_perm),
        .wr_en(k4_wr), .wr_vpn(rf_req_vpn), .wr_pid(rf_req_pid),
        .wr_ppn(rf_rsp_ppn), .wr_perm(rf_rsp_perm),
        .inv_en(inv_valid), .inv_vpn(inv_vpn), .inv_pid(inv_pid)
    );

    l1tlb_ctrl #(
        .VPN_W(VPN_W), .PID_W(PID_W), .PERM_W(PERM_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_pid(lk_pid), .lk_busy(lk_busy),
        .lu_vpn(lu_vpn), .lu_pid(lu_pid),
        .vsp_hit(vsp_hit), .vsp_multi(vsp_multi), .vsp_ppn(vsp_ppn), .vsp_perm(vsp_perm),
        .k4_hit(k4_hit), .k4_multi(k4_multi), .k4_ppn(k4_ppn), .k4_perm(k4_perm),
        .rf_rsp_valid(rf_rsp_valid), .rf_rsp_to_vsp(rf_rsp_to_vsp),
        .inv_valid(inv_valid), .inv_vpn(inv_vpn), .inv_pid(inv_pid),
        .vsp_wr(vsp_wr), .k4_wr(k4_wr),
        .rf_req_valid(rf_req_valid), .rf_req_vpn(rf_req_vpn), .rf_req_pid(rf_req_pid),
        .rsp_valid(rsp_valid), .rsp_ppn(rsp_ppn), .rsp_perm(rsp_perm),
        .rsp_from_vsp(rsp_from_vsp), .rsp_multihit(rsp_multihit)
    );

    assert_req_implies_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_req_valid |-> lk_busy);

    assert_rsp_not_while_waiting_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !rf_req_valid);
endmodule

// File: tb/l1_split_tlb_bench.sv
`timescale 1ns/1ps
// Bench: walks a vector table of lookups/refills against a behavioural
// model of both arrays, then runs directed tests for reset, priority,
// multi-hit, replacement order and invalidation.
module l1_split_tlb_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_pid = '0;
    logic        lk_busy, rsp_valid, rsp_from_vsp, rsp_multihit, rf_req_valid;
    logic [19:0] rsp_ppn, rf_req_vpn;
    logic [2:0]  rsp_perm;
    logic [7:0]  rf_req_pid;
    logic        rf_rsp_valid = 1'b0, rf_rsp_to_vsp = 1'b0;
    logic [3:0]  rf_rsp_psz = '0;
    logic [19:0] rf_rsp_ppn = '0;
    logic [2:0]  rf_rsp_perm = '0;
    logic        inv_valid = 1'b0;
    logic [19:0] inv_vpn = '0;
    logic [7:0]  inv_pid = '0;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    l1_split_tlb u_l1_split_tlb (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_pid(lk_pid), .lk_busy(lk_busy),
        .rsp_valid(rsp_valid), .rsp_ppn(rsp_ppn), .rsp_perm(rsp_perm),
        .rsp_from_vsp(rsp_from_vsp), .rsp_multihit(rsp_multihit),
        .rf_req_valid(rf_req_valid), .rf_req_vpn(rf_req_vpn), .rf_req_pid(rf_req_pid),
        .rf_rsp_valid(rf_rsp_valid), .rf_rsp_to_vsp(rf_rsp_to_vsp), .rf_rsp_psz(rf_rsp_psz),
        .rf_rsp_ppn(rf_rsp_ppn), .rf_rsp_perm(rf_rsp_perm),
        .inv_valid(inv_valid), .inv_vpn(inv_vpn), .inv_pid(inv_pid)
    );

    // Behavioural model of both arrays, built from the requirements.
    bit          mv_v   [4];
    logic [19:0] mv_vpn [4];
    logic [7:0]  mv_pid [4];
    logic [3:0]  mv_psz [4];
    logic [19:0] mv_ppn [4];
    logic [2:0]  mv_perm[4];
    int          mv_ptr;
    bit          mk_v   [16][4];
    logic [19:0] mk_vpn [16][4];
    logic [7:0]  mk_pid [16][4];
    logic [19:0] mk_ppn [16][4];
    logic [2:0]  mk_perm[16][4];
    int          mk_ptr [16];

    function automatic logic [19:0] m_mask(input logic [3:0] psz);
        return 20'hFFFFF << (2 * int'(psz));
    endfunction

    function automatic void m_reset();
        mv_ptr = 0;
        for (int i = 0; i < 4; i++) mv_v[i] = 0;
        for (int s = 0; s < 16; s++) begin
            mk_ptr[s] = 0;
            for (int w = 0; w < 4; w++) mk_v[s][w] = 0;
        end
    endfunction

    function automatic void m_look(input logic [19:0] vpn, input logic [7:0] pid,
                                   output bit hit, output logic [19:0] ppn,
                                   output logic [2:0] perm, output bit src, output bit multi);
        int nv = 0, nk = 0, fv = -1, fk = -1;
        int s = int'(vpn[3:0]);
        for (int i = 0; i < 4; i++)
            if (mv_v[i] && mv_pid[i] == pid && ((mv_vpn[i] ^ vpn) & m_mask(mv_psz[i])) == 0) begin
                nv++; if (fv < 0) fv = i;
            end
        for (int w = 0; w < 4; w++)
            if (mk_v[s][w] && mk_pid[s][w] == pid && mk_vpn[s][w][19:4] == vpn[19:4]) begin
                nk++; if (fk < 0) fk = w;
            end
        hit = (nv + nk) > 0;
        multi = (nv > 1) || (nk > 1);
        src = nv > 0;
        ppn = '0; perm = '0;
        if (fv >= 0) begin
            ppn  = (mv_ppn[fv] & m_mask(mv_psz[fv])) | (vpn & ~m_mask(mv_psz[fv]));
            perm = mv_perm[fv];
        end else if (fk >= 0) begin
            ppn  = mk_ppn[s][fk];
            perm = mk_perm[s][fk];
        end
    endfunction

    function automatic void m_install(input logic [19:0] vpn, input logic [7:0] pid, input bit to_vsp,
                                      input logic [3:0] psz, input logic [19:0] ppn, input logic [2:0] perm);
        int s = int'(vpn[3:0]);
        if (to_vsp) begin
            mv_v[mv_ptr] = 1; mv_vpn[mv_ptr] = vpn; mv_pid[mv_ptr] = pid;
            mv_psz[mv_ptr] = (psz > 4'd8) ? 4'd8 : psz;
            mv_ppn[mv_ptr] = ppn; mv_perm[mv_ptr] = perm;
            mv_ptr = (mv_ptr + 1) % 4;
        end else begin
            mk_v[s][mk_ptr[s]] = 1; mk_vpn[s][mk_ptr[s]] = vpn; mk_pid[s][mk_ptr[s]] = pid;
            mk_ppn[s][mk_ptr[s]] = ppn; mk_perm[s][mk_ptr[s]] = perm;
            mk_ptr[s] = (mk_ptr[s] + 1) % 4;
        end
    endfunction

    function automatic void m_inv(input logic [19:0] vpn, input logic [7:0] pid);
        int s = int'(vpn[3:0]);
        for (int i = 0; i < 4; i++)
            if (mv_v[i] && mv_pid[i] == pid && ((mv_vpn[i] ^ vpn) & m_mask(mv_psz[i])) == 0) mv_v[i] = 0;
        for (int w = 0; w < 4; w++)
            if (mk_v[s][w] && mk_pid[s][w] == pid && mk_vpn[s][w][19:4] == vpn[19:4]) mk_v[s][w] = 0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare the registered result with the model's prediction.
    task automatic chk_rsp(input string req, input logic [19:0] vpn, input logic [7:0] pid);
        bit h, s, m; logic [19:0] p; logic [2:0] pm;
        m_look(vpn, pid, h, p, pm, s, m);
        chk(rsp_valid == 1'b1, req, "rsp_valid", 32'(rsp_valid), 32'(1));
        chk(rsp_ppn == p, req, "rsp_ppn", 32'(rsp_ppn), 32'(p));
        chk(rsp_perm == pm, req, "rsp_perm", 32'(rsp_perm), 32'(pm));
        chk(rsp_from_vsp == s, req, "rsp_from_vsp", 32'(rsp_from_vsp), 32'(s));
        chk(rsp_multihit == m, req, "rsp_multihit", 32'(rsp_multihit), 32'(m));
        chk(lk_busy == 1'b0, req, "lk_busy after result", 32'(lk_busy), 32'(0));
    endtask

    // One refill answer; a stray lookup is presented meanwhile (must be ignored).
    task automatic give_refill(input logic [19:0] vpn, input bit to_vsp, input logic [3:0] psz,
                               input logic [19:0] ppn, input logic [2:0] perm);
        rf_rsp_valid = 1; rf_rsp_to_vsp = to_vsp; rf_rsp_psz = psz;
        rf_rsp_ppn = ppn; rf_rsp_perm = perm;
        lk_valid = 1; lk_vpn = ~vpn;
        @(negedge clk);
        rf_rsp_valid = 0; lk_valid = 0;
        @(negedge clk);
    endtask

    // Lookup; on predicted miss check the request, refill, then check the replay.
    task automatic lookup(input string req, input logic [19:0] vpn, input logic [7:0] pid,
                          input bit to_vsp, input logic [3:0] psz, input logic [19:0] ppn,
                          input logic [2:0] perm, input bit inv_mid);
        bit h, s, m; logic [19:0] p; logic [2:0] pm;
        m_look(vpn, pid, h, p, pm, s, m);
        @(negedge clk);
        lk_valid = 1; lk_vpn = vpn; lk_pid = pid;
        @(negedge clk);
        lk_valid = 0;
        if (h) begin
            chk_rsp(req, vpn, pid);
        end else begin
            chk(rsp_valid == 1'b0, req, "rsp_valid on miss", 32'(rsp_valid), 32'(0));
            chk(lk_busy == 1'b1, "R5", "lk_busy on miss", 32'(lk_busy), 32'(1));
            chk(rf_req_valid == 1'b1, "R5", "rf_req_valid", 32'(rf_req_valid), 32'(1));
            chk(rf_req_vpn == vpn, "R5", "rf_req_vpn", 32'(rf_req_vpn), 32'(vpn));
            chk(rf_req_pid == pid, "R5", "rf_req_pid", 32'(rf_req_pid), 32'(pid));
            if (inv_mid) begin
                inv_valid = 1; inv_vpn = vpn; inv_pid = pid;
                m_inv(vpn, pid);
                @(negedge clk);
                inv_valid = 0;
                give_refill(vpn, to_vsp, psz, ppn ^ 20'h0F0F0, perm);
                chk(rsp_valid == 1'b0, "R10", "rsp_valid after stale answer", 32'(rsp_valid), 32'(0));
                chk(rf_req_valid == 1'b1, "R10", "new rf_req_valid", 32'(rf_req_valid), 32'(1));
                chk(rf_req_vpn == vpn, "R10", "new rf_req_vpn", 32'(rf_req_vpn), 32'(vpn));
                @(negedge clk);
            end
            give_refill(vpn, to_vsp, psz, ppn, perm);
            m_install(vpn, pid, to_vsp, psz, ppn, perm);
            chk_rsp(req, vpn, pid);
        end
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R2", "rsp_valid one cycle only", 32'(rsp_valid), 32'(0));
    endtask

    task automatic invalidate(input logic [19:0] vpn, input logic [7:0] pid);
        @(negedge clk);
        inv_valid = 1; inv_vpn = vpn; inv_pid = pid;
        m_inv(vpn, pid);
        @(negedge clk);
        inv_valid = 0;
    endtask

    // Vector fields: {vpn[20], pid[8], to_vsp[1], psz[4], ppn[20], perm[3]}
    localparam int NVEC = 9;
    localparam logic [55:0] VEC [NVEC] = '{
        {20'h12345, 8'h11, 1'b0, 4'd0, 20'hAAAA5, 3'd5},  // R4 4 KB install
        {20'h12345, 8'h11, 1'b0, 4'd0, 20'h00000, 3'd0},  // R2 hit
        {20'h40000, 8'h11, 1'b1, 4'd4, 20'h80000, 3'd3},  // R3 1 MB page
        {20'h400AB, 8'h11, 1'b0, 4'd0, 20'h00000, 3'd0},  // R3 offset merge
        {20'h40100, 8'h11, 1'b1, 4'd0, 20'h11111, 3'd1},  // R3 outside 1 MB
        {20'h12345, 8'h22, 1'b0, 4'd0, 20'h33333, 3'd7},  // R4 other tag
        {20'h80000, 8'h11, 1'b1, 4'd8, 20'hF0000, 3'd6},  // R3 256 MB page
        {20'h8ABCD, 8'h11, 1'b0, 4'd0, 20'h00000, 3'd0},  // R3 offset merge
        {20'h12345, 8'h11, 1'b0, 4'd0, 20'h00000, 3'd0}   // R4 still present
    };

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(lk_busy == 1'b0, "R1", "lk_busy after reset", 32'(lk_busy), 32'(0));
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'(0));
        chk(rf_req_valid == 1'b0, "R1", "rf_req_valid after reset", 32'(rf_req_valid), 32'(0));

        for (int i = 0; i < NVEC; i++) begin
            lookup("R6", VEC[i][55:36], VEC[i][35:28], VEC[i][27], VEC[i][26:23],
                   VEC[i][22:3], VEC[i][2:0], 1'b0);
        end

        // R7: 64 KB variable slot overlapping the 4 KB slot at 0x12345.
        lookup("R7", 20'h12340, 8'h11, 1'b1, 4'd2, 20'h66660, 3'd2, 1'b0);
        lookup("R7", 20'h12345, 8'h11, 1'b0, 4'd0, 20'h0, 3'd0, 1'b0);
        chk(rsp_from_vsp == 1'b1, "R7", "variable array wins", 32'(rsp_from_vsp), 32'(1));

        // R8 and R12: fifth variable install wraps to slot 0, overlapping slot 1.
        lookup("R12", 20'h40105, 8'h11, 1'b1, 4'd4, 20'h77700, 3'd6, 1'b0);
        lookup("R8", 20'h40100, 8'h11, 1'b0, 4'd0, 20'h0, 3'd0, 1'b0);
        lookup("R12", 20'h400AB, 8'h11, 1'b1, 4'd0, 20'h12121, 3'd1, 1'b0);

        // R11: five installs into set 7.
        for (int k = 0; k < 5; k++) begin
            lookup("R11", 20'h00007 + 20'(k * 16), 8'h11, 1'b0, 4'd0, 20'h50000 + 20'(k), 3'd4, 1'b0);
        end
        lookup("R11", 20'h00017, 8'h11, 1'b0, 4'd0, 20'h0, 3'd0, 1'b0);
        lookup("R11", 20'h00007, 8'h11, 1'b0, 4'd0, 20'h5A5A5, 3'd2, 1'b0);

        // R9: clear the 256 MB slot; a foreign tag leaves the other-tag slot.
        invalidate(20'h8ABCD, 8'h11);
        lookup("R9", 20'h80000, 8'h11, 1'b0, 4'd0, 20'h24680, 3'd3, 1'b0);
        invalidate(20'h12345, 8'h33);
        lookup("R9", 20'h12345, 8'h22, 1'b0, 4'd0, 20'h0, 3'd0, 1'b0);

        // R10: matching invalidate while the refill is outstanding.
        lookup("R10", 20'h55555, 8'h11, 1'b0, 4'd0, 20'h13579, 3'd5, 1'b1);
        lookup("R10", 20'h55555, 8'h11, 1'b0, 4'd0, 20'h0, 3'd0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule